// File: doc/BRIEF.md
# Helper-Thread Spawn Controller for Ordered Speculative Tasks

This block arbitrates the cores of a small chip multiprocessor that runs ordered speculative tasks. It keeps the role of every core (idle, ordered task or helper clone) and the age order of the live tasks. When a task takes a miss in the shared second-level cache, the block decides whether that task may clone itself onto a free core as a helper that keeps running in runahead mode on a predicted load value. The helper's results are thrown away. It never commits, never squashes another task and ignores squashes aimed at it.

A table of 2-bit saturating counters, indexed by the low bits of the load address, decides whether the missing load's value may be predicted. The same answer gates every spawn. The block also retires helpers. A helper is killed when its parent stops being the youngest (most speculative) task, when the parent finishes or is squashed, and when the helper finishes or raises an exception. Spawn and kill commands appear one cycle after the events that cause them.

Top module: `hspawn_ctrl`

## Requirements
- R1: `core_role` shows each core's state (2 bits per core: 0 idle, 1 ordered task, 2 helper). A task start is accepted only onto an idle core, which reads 1 after the next edge and becomes the youngest task.
- R2: `predict_en` is high in the same cycle only when `miss_valid` is high and the counter selected by `miss_addr[CONF_IDX_W-1:0]` equals 3. A correct outcome increments that counter up to a ceiling of 3. A wrong outcome clears it to 0. All counters reset to 0.
- R3: A spawn needs `predict_en`, a missing core that holds an ordered task and at least one idle core. The helper goes to the lowest-numbered idle core. One cycle later `spawn_valid` pulses with `spawn_core`/`spawn_parent`, and the target reads 2. When no spawn occurs, `spawn_core` and `spawn_parent` read 0.
- R4: Only the youngest ordered task may spawn. A miss from an older task never spawns.
- R5: Every live helper is killed when a new task start is accepted, and when its parent finishes or is squashed.
- R6: A helper is killed when it finishes or raises an exception. A squash aimed at a helper core, and an exception on an ordered task, change nothing.
- R7: A kill pulses its bit in `kill_mask` one cycle later, with that core back to idle. No spawn is granted in a cycle in which any kill is issued or the task order changes.
- R8: A parent owns at most one helper. A further miss from it while its helper lives is refused.
- R9: At most one order event is accepted per cycle, with priority squash, then finish, then start. A squash removes the task and every younger task. A finish removes only that task.
- R10: After reset every core is idle, and `spawn_valid` and `kill_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Second-level cache miss event |
| miss_core | input | CORE_W | Core that took the miss |
| miss_addr | input | ADDR_W | Address of the missing load |
| task_start_valid | input | 1 | New ordered task starts |
| task_start_core | input | CORE_W | Core receiving the new task |
| finish_valid | input | 1 | A task or helper finishes |
| finish_core | input | CORE_W | Finishing core |
| squash_valid | input | 1 | Squash request |
| squash_core | input | CORE_W | Core targeted by the squash |
| exc_valid | input | 1 | Exception raised |
| exc_core | input | CORE_W | Core raising the exception |
| vp_upd_valid | input | 1 | Value-prediction outcome |
| vp_upd_addr | input | ADDR_W | Load address of that outcome |
| vp_upd_correct | input | 1 | 1 when the prediction was right |
| predict_en | output | 1 | Predict the missing load's value |
| spawn_valid | output | 1 | Helper spawn command |
| spawn_core | output | CORE_W | Core receiving the helper |
| spawn_parent | output | CORE_W | Task being cloned |
| kill_mask | output | NUM_CORES | Helpers killed, one bit per core |
| core_role | output | 2*NUM_CORES | Per-core role code |

## Verification
The assertions check four things on every cycle. Only one task is ever the youngest. Any core that owns a helper is that youngest task. No spawn meets a kill or reuses a parent that already owns a helper. A wrong outcome leaves its counter unconfident. The order-dependent effects can only be seen through the bench's scenarios: a squash removing several younger tasks, a finish of the oldest task leaving a helper alive, squash priority over a start in the same cycle, the lowest idle core being chosen, and the counter needing three correct outcomes in a row. A reference model in the bench follows these effects across long random event mixes.

// File: rtl/hspawn_pkg.sv
package hspawn_pkg;
   typedef enum logic [1:0] {
      ROLE_IDLE   = 2'd0,
      ROLE_TASK   = 2'd1,
      ROLE_HELPER = 2'd2
   } core_role_e;
endpackage

// File: rtl/hspawn_conf_table.sv
module hspawn_conf_table #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4,
   parameter int CTR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_addr,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_correct,
   output logic              look_conf
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("IDX_W out of range");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("IDX_W wider than ADDR_W");
   end

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [IDX_W-1:0] look_idx, upd_idx;

   assign look_idx  = look_addr[IDX_W-1:0];
   assign upd_idx   = upd_addr[IDX_W-1:0];
   assign look_conf = (ctr_q[look_idx] == CTR_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) ctr_q[e] <= '0;
      end else if (upd_valid) begin
         if (!upd_correct)                  ctr_q[upd_idx] <= '0;
         else if (ctr_q[upd_idx] != CTR_MAX) ctr_q[upd_idx] <= ctr_q[upd_idx] + 1'b1;
      end
   end

   // R2: a wrong outcome leaves that entry unconfident on the next cycle
   a_r2_wrong_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_correct) |=> (look_idx != $past(upd_idx)) || !look_conf);
endmodule

// File: rtl/hspawn_order.sv
module hspawn_order #(
   parameter int NUM_CORES = 4,
   localparam int RW = $clog2(NUM_CORES),
   localparam int CW = $clog2(NUM_CORES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sq_ok,
   input  logic [RW-1:0]        sq_core,
   input  logic                 fin_ok,
   input  logic [RW-1:0]        fin_core,
   input  logic                 st_ok,
   input  logic [RW-1:0]        st_core,
   output logic [NUM_CORES-1:0] task_mask,
   output logic [NUM_CORES-1:0] young_mask,
   output logic [NUM_CORES-1:0] rm_mask
);
   logic [RW-1:0] rank_q [NUM_CORES];
   logic [NUM_CORES-1:0] task_q;
   logic [CW-1:0] cnt;
   logic [RW-1:0] young_rank, sq_rank, fin_rank;

   assign task_mask  = task_q;
   assign cnt        = CW'($countones(task_q));
   assign young_rank = RW'(cnt - CW'(1));
   assign sq_rank    = rank_q[sq_core];
   assign fin_rank   = rank_q[fin_core];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign young_mask[c] = task_q[c] && (rank_q[c] == young_rank);
      assign rm_mask[c] = sq_ok ? (task_q[c] && (rank_q[c] >= sq_rank))
                                : (fin_ok && (fin_core == RW'(c)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         task_q <= '0;
         for (int c = 0; c < NUM_CORES; c++) rank_q[c] <= '0;
      end else begin
         for (int c = 0; c < NUM_CORES; c++) begin
            if (rm_mask[c]) begin
               task_q[c] <= 1'b0;
            end else if (st_ok && (st_core == RW'(c))) begin
               task_q[c] <= 1'b1;
               rank_q[c] <= RW'(cnt);
            end else if (fin_ok && task_q[c] && (rank_q[c] > fin_rank)) begin
               rank_q[c] <= rank_q[c] - 1'b1;
            end
         end
      end
   end

   // R9: exactly one youngest task whenever any task is live
   a_r9_young_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(young_mask) && ((task_q == '0) || (young_mask != '0)));
   // R1: an accepted start makes that core an ordered task
   a_r1_start_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ok && !sq_ok && !fin_ok) |=> task_q[$past(st_core)]);
endmodule

// File: rtl/hspawn_helpers.sv
module hspawn_helpers #(
   parameter int NUM_CORES = 4,
   localparam int RW = $clog2(NUM_CORES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 st_ok,
   input  logic [NUM_CORES-1:0] rm_mask,
   input  logic                 fin_valid,
   input  logic [RW-1:0]        fin_core,
   input  logic                 exc_valid,
   input  logic [RW-1:0]        exc_core,
   input  logic                 spawn_go,
   input  logic [RW-1:0]        spawn_tgt,
   input  logic [RW-1:0]        spawn_par,
   output logic [NUM_CORES-1:0] helper_mask,
   output logic [NUM_CORES-1:0] own_mask,
   output logic [NUM_CORES-1:0] kill_now
);
   logic [NUM_CORES-1:0] hv_q;
   logic [RW-1:0] hpar_q [NUM_CORES];

   assign helper_mask = hv_q;

   for (genvar h = 0; h < NUM_CORES; h++) begin : g_kill
      assign kill_now[h] = hv_q[h] &&
         (st_ok || rm_mask[hpar_q[h]] ||
          (fin_valid && (fin_core == RW'(h))) ||
          (exc_valid && (exc_core == RW'(h))));
      // R7: a killed helper's core is not a helper on the next cycle
      a_r7_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
         kill_now[h] |=> !hv_q[h]);
   end

   always_comb begin
      own_mask = '0;
      for (int h = 0; h < NUM_CORES; h++)
         if (hv_q[h]) own_mask[hpar_q[h]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hv_q <= '0;
         for (int h = 0; h < NUM_CORES; h++) hpar_q[h] <= '0;
      end else begin
         for (int h = 0; h < NUM_CORES; h++) begin
            if (kill_now[h]) begin
               hv_q[h] <= 1'b0;
            end else if (spawn_go && (spawn_tgt == RW'(h))) begin
               hv_q[h]   <= 1'b1;
               hpar_q[h] <= spawn_par;
            end
         end
      end
   end

   // R7: kill wins over spawn
   a_r7_no_spawn_on_kill: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_go |-> (kill_now == '0));
   // R8: one helper per parent
   a_r8_one_per_parent: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_go |-> !own_mask[spawn_par]);
endmodule

// File: rtl/hspawn_ctrl.sv
module hspawn_ctrl #(
   parameter int NUM_CORES  = 4,
   parameter int ADDR_W     = 32,
   parameter int CONF_IDX_W = 4,
   parameter bit OUT_REG    = 1'b1,
   localparam int CORE_W = $clog2(NUM_CORES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   miss_valid,
   input  logic [CORE_W-1:0]      miss_core,
   input  logic [ADDR_W-1:0]      miss_addr,
   input  logic                   task_start_valid,
   input  logic [CORE_W-1:0]      task_start_core,
   input  logic                   finish_valid,
   input  logic [CORE_W-1:0]      finish_core,
   input  logic                   squash_valid,
   input  logic [CORE_W-1:0]      squash_core,
   input  logic                   exc_valid,
   input  logic [CORE_W-1:0]      exc_core,
   input  logic                   vp_upd_valid,
   input  logic [ADDR_W-1:0]      vp_upd_addr,
   input  logic                   vp_upd_correct,
   output logic                   predict_en,
   output logic                   spawn_valid,
   output logic [CORE_W-1:0]      spawn_core,
   output logic [CORE_W-1:0]      spawn_parent,
   output logic [NUM_CORES-1:0]   kill_mask,
   output logic [2*NUM_CORES-1:0] core_role
);
   import hspawn_pkg::*;

   if (NUM_CORES < 2 || NUM_CORES > 64) begin : g_bad_cores
      $error("NUM_CORES out of range");
   end

   logic [NUM_CORES-1:0] task_mask, young_mask, rm_mask;
   logic [NUM_CORES-1:0] helper_mask, own_mask, kill_now, idle_mask;
   logic sq_ok, fin_ok, st_ok, order_evt, look_conf, any_idle, spawn_go;
   logic [CORE_W-1:0] free_core;

   assign idle_mask = ~(task_mask | helper_mask);

   // one order event per cycle: squash, then finish, then start
   assign sq_ok  = squash_valid && task_mask[squash_core];
   assign fin_ok = !sq_ok && finish_valid && task_mask[finish_core];
   assign st_ok  = !sq_ok && !fin_ok && task_start_valid && idle_mask[task_start_core];
   assign order_evt = sq_ok || fin_ok || st_ok;

   hspawn_conf_table #(.ADDR_W(ADDR_W), .IDX_W(CONF_IDX_W), .CTR_W(2)) u_conf (
      .clk(clk), .rst_n(rst_n), .look_addr(miss_addr),
      .upd_valid(vp_upd_valid), .upd_addr(vp_upd_addr),
      .upd_correct(vp_upd_correct), .look_conf(look_conf));

   assign predict_en = miss_valid && look_conf;

   hspawn_order #(.NUM_CORES(NUM_CORES)) u_order (
      .clk(clk), .rst_n(rst_n),
      .sq_ok(sq_ok), .sq_core(squash_core),
      .fin_ok(fin_ok), .fin_core(finish_core),
      .st_ok(st_ok), .st_core(task_start_core),
      .task_mask(task_mask), .young_mask(young_mask), .rm_mask(rm_mask));

   always_comb begin
      free_core = '0;
      any_idle  = 1'b0;
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
         if (idle_mask[c]) begin
            free_core = CORE_W'(c);
            any_idle  = 1'b1;
         end
      end
   end

   assign spawn_go = miss_valid && task_mask[miss_core] && young_mask[miss_core] &&
                     predict_en && !own_mask[miss_core] && any_idle &&
                     !order_evt && (kill_now == '0);

   hspawn_helpers #(.NUM_CORES(NUM_CORES)) u_help (
      .clk(clk), .rst_n(rst_n), .st_ok(st_ok), .rm_mask(rm_mask),
      .fin_valid(finish_valid), .fin_core(finish_core),
      .exc_valid(exc_valid), .exc_core(exc_core),
      .spawn_go(spawn_go), .spawn_tgt(free_core), .spawn_par(miss_core),
      .helper_mask(helper_mask), .own_mask(own_mask), .kill_now(kill_now));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_role
      assign core_role[2*c +: 2] = task_mask[c]   ? ROLE_TASK :
                                   helper_mask[c] ? ROLE_HELPER : ROLE_IDLE;
      // R4: a core owning a helper is always the youngest task
      a_r4_owner_youngest: assert property (@(posedge clk) disable iff (!rst_n)
         own_mask[c] |-> young_mask[c]);
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            spawn_valid  <= 1'b0;
            spawn_core   <= '0;
            spawn_parent <= '0;
            kill_mask    <= '0;
         end else begin
            spawn_valid  <= spawn_go;
            spawn_core   <= spawn_go ? free_core : '0;
            spawn_parent <= spawn_go ? miss_core : '0;
            kill_mask    <= kill_now;
         end
      end
   end else begin : g_out_comb
      assign spawn_valid  = spawn_go;
      assign spawn_core   = spawn_go ? free_core : '0;
      assign spawn_parent = spawn_go ? miss_core : '0;
      assign kill_mask    = kill_now;
   end

   // R3: the spawn target is idle and turns into a helper
   a_r3_target_idle: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_go |-> idle_mask[free_core]);
   a_r3_target_helper: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_go |=> helper_mask[$past(free_core)]);
   // R6: a helper is never also an ordered task
   a_r6_roles_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (task_mask & helper_mask) == '0);
endmodule

// File: tb/hspawn_ctrl_test.sv
module hspawn_ctrl_test;
   localparam int N = 4, AW = 32, IW = 4, CWB = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic miss_valid, task_start_valid, finish_valid, squash_valid, exc_valid;
   logic vp_upd_valid, vp_upd_correct;
   logic [CWB-1:0] miss_core, task_start_core, finish_core, squash_core, exc_core;
   logic [AW-1:0] miss_addr, vp_upd_addr;
   logic predict_en, spawn_valid;
   logic [CWB-1:0] spawn_core, spawn_parent;
   logic [N-1:0] kill_mask;
   logic [2*N-1:0] core_role;

   hspawn_ctrl #(.NUM_CORES(N), .ADDR_W(AW), .CONF_IDX_W(IW)) uut (.*);

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   int m_role[N], m_rank[N], m_par[N], m_conf[1<<IW];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int role_of(int c);
      return int'(core_role[2*c +: 2]);
   endfunction

   task automatic clr();
      miss_valid = 0; task_start_valid = 0; finish_valid = 0; squash_valid = 0;
      exc_valid = 0; vp_upd_valid = 0; vp_upd_correct = 0;
      miss_core = 0; task_start_core = 0; finish_core = 0; squash_core = 0;
      exc_core = 0; miss_addr = 0; vp_upd_addr = 0;
   endtask

   // one cycle: inputs already driven after a negedge
   task automatic step();
      int sq_ok, fin_ok, st_ok, ord, cnt, young, pe, tgt, go, anyk, own, idx;
      int rm[N], kl[N], nrole[N], nrank[N], npar[N];
      #1;
      pe = (miss_valid && m_conf[int'(miss_addr[IW-1:0])] == 3) ? 1 : 0;
      chk(predict_en == pe, "R2", "predict_en", predict_en, pe);
      sq_ok  = (squash_valid && m_role[squash_core] == 1) ? 1 : 0;
      fin_ok = (!sq_ok && finish_valid && m_role[finish_core] == 1) ? 1 : 0;
      st_ok  = (!sq_ok && !fin_ok && task_start_valid && m_role[task_start_core] == 0) ? 1 : 0;
      ord = sq_ok | fin_ok | st_ok;
      cnt = 0;
      for (int c = 0; c < N; c++) if (m_role[c] == 1) cnt++;
      young = -1;
      for (int c = 0; c < N; c++) if (m_role[c] == 1 && m_rank[c] == cnt - 1) young = c;
      for (int c = 0; c < N; c++)
         rm[c] = sq_ok ? ((m_role[c] == 1 && m_rank[c] >= m_rank[squash_core]) ? 1 : 0)
                       : ((fin_ok && c == finish_core) ? 1 : 0);
      anyk = 0; own = 0;
      for (int h = 0; h < N; h++) begin
         kl[h] = (m_role[h] == 2 && (st_ok || rm[m_par[h]] ||
                 (finish_valid && finish_core == h) || (exc_valid && exc_core == h))) ? 1 : 0;
         anyk |= kl[h];
         if (m_role[h] == 2 && m_par[h] == miss_core) own = 1;
      end
      tgt = -1;
      for (int c = N - 1; c >= 0; c--) if (m_role[c] == 0) tgt = c;
      go = (miss_valid && m_role[miss_core] == 1 && young == miss_core && pe &&
            !own && tgt >= 0 && !ord && !anyk) ? 1 : 0;
      for (int c = 0; c < N; c++) begin
         nrole[c] = m_role[c]; nrank[c] = m_rank[c]; npar[c] = m_par[c];
         if (rm[c] || kl[c]) nrole[c] = 0;
         else if (st_ok && c == task_start_core) begin nrole[c] = 1; nrank[c] = cnt; end
         else if (fin_ok && m_role[c] == 1 && m_rank[c] > m_rank[finish_core]) nrank[c]--;
      end
      if (go) begin nrole[tgt] = 2; npar[tgt] = miss_core; end
      if (vp_upd_valid) begin
         idx = int'(vp_upd_addr[IW-1:0]);
         m_conf[idx] = vp_upd_correct ? ((m_conf[idx] < 3) ? m_conf[idx] + 1 : 3) : 0;
      end
      m_role = nrole; m_rank = nrank; m_par = npar;
      @(posedge clk); @(negedge clk);
      chk(spawn_valid == go, "R3", "spawn_valid", spawn_valid, go);
      chk(int'(spawn_core) == (go ? tgt : 0), "R3", "spawn_core", spawn_core, go ? tgt : 0);
      chk(int'(spawn_parent) == (go ? int'(miss_core) : 0), "R3", "spawn_parent",
          spawn_parent, go ? int'(miss_core) : 0);
      for (int h = 0; h < N; h++)
         chk(kill_mask[h] == kl[h], "R5", $sformatf("kill_mask[%0d]", h), kill_mask[h], kl[h]);
      for (int c = 0; c < N; c++)
         chk(role_of(c) == m_role[c], "R1", $sformatf("core_role[%0d]", c), role_of(c), m_role[c]);
      clr();
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      clr();
      for (int c = 0; c < N; c++) begin m_role[c] = 0; m_rank[c] = 0; m_par[c] = 0; end
      for (int e = 0; e < (1 << IW); e++) m_conf[e] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      chk(core_role == '0, "R10", "core_role", core_role, 0);
      chk(spawn_valid == 0 && kill_mask == 0, "R10", "spawn/kill", {spawn_valid, kill_mask}, 0);

      task_start_valid = 1; task_start_core = 2; step();
      vp_upd_valid = 1; vp_upd_addr = 5; vp_upd_correct = 1; step();
      vp_upd_valid = 1; vp_upd_addr = 5; vp_upd_correct = 1; step();
      // R2: two correct outcomes are not enough
      miss_valid = 1; miss_core = 2; miss_addr = 5; #1;
      chk(predict_en == 0, "R2", "predict after two", predict_en, 0);
      step();
      chk(spawn_valid == 0, "R3", "spawn without confidence", spawn_valid, 0);
      vp_upd_valid = 1; vp_upd_addr = 5; vp_upd_correct = 1; step();
      // R3: lowest idle core receives the helper
      miss_valid = 1; miss_core = 2; miss_addr = 32'h105; step();
      chk(spawn_valid && spawn_core == 0 && spawn_parent == 2, "R3", "spawn to core0",
          {spawn_core, spawn_parent}, 2);
      // R8: second miss from the same parent refused
      miss_valid = 1; miss_core = 2; miss_addr = 5; step();
      chk(spawn_valid == 0, "R8", "second helper", spawn_valid, 0);
      // R6: squash aimed at the helper ignored
      squash_valid = 1; squash_core = 0; step();
      chk(role_of(0) == 2 && kill_mask == 0, "R6", "helper after squash", role_of(0), 2);
      // R7/R5: new task kills helper, same-cycle spawn refused
      task_start_valid = 1; task_start_core = 1; miss_valid = 1; miss_core = 2; miss_addr = 5; step();
      chk(kill_mask == 4'b0001 && spawn_valid == 0, "R7", "kill over spawn", kill_mask, 1);
      chk(role_of(0) == 0, "R5", "helper freed", role_of(0), 0);
      // R4: older task may not spawn
      miss_valid = 1; miss_core = 2; miss_addr = 5; step();
      chk(spawn_valid == 0, "R4", "older task spawn", spawn_valid, 0);
      miss_valid = 1; miss_core = 1; miss_addr = 5; step();
      chk(spawn_valid && spawn_core == 0 && spawn_parent == 1, "R4", "youngest spawns",
          spawn_parent, 1);
      // R9: finishing the oldest task keeps the helper
      finish_valid = 1; finish_core = 2; step();
      chk(kill_mask == 0 && role_of(0) == 2 && role_of(2) == 0, "R9", "finish oldest",
          kill_mask, 0);
      // R6: exception on the task ignored, on the helper kills it
      exc_valid = 1; exc_core = 1; step();
      chk(role_of(1) == 1 && role_of(0) == 2, "R6", "task exception", role_of(1), 1);
      exc_valid = 1; exc_core = 0; step();
      chk(kill_mask == 4'b0001 && role_of(0) == 0, "R6", "helper exception", kill_mask, 1);
      // R9: squash beats start and removes younger tasks
      task_start_valid = 1; task_start_core = 2; step();
      squash_valid = 1; squash_core = 1; task_start_valid = 1; task_start_core = 3; step();
      chk(core_role == '0, "R9", "squash cascade", core_role, 0);
      // R2: wrong outcome clears confidence
      vp_upd_valid = 1; vp_upd_addr = 5; vp_upd_correct = 0; step();
      miss_valid = 1; miss_core = 0; miss_addr = 5; #1;
      chk(predict_en == 0, "R2", "after wrong", predict_en, 1'b0);
      step();

      for (int i = 0; i < 4000; i++) begin
         miss_valid = ($urandom % 3) == 0;
         miss_core = 2'($urandom);
         miss_addr = (($urandom % 2) << 4) + ($urandom % 4);
         task_start_valid = ($urandom % 5) == 0; task_start_core = 2'($urandom);
         finish_valid = ($urandom % 9) == 0;     finish_core = 2'($urandom);
         squash_valid = ($urandom % 17) == 0;    squash_core = 2'($urandom);
         exc_valid = ($urandom % 13) == 0;       exc_core = 2'($urandom);
         vp_upd_valid = ($urandom % 2) == 0;
         vp_upd_addr = $urandom % 4;
         vp_upd_correct = ($urandom % 10) != 0;
         step();
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule